// File: doc/BRIEF.md
# Auto-Stepping Address Pointer Unit

This block keeps four address pointers for a load/store datapath and produces the memory address for an operand access that can walk through memory on its own. Each request names one pointer, an access mode and an element width. The block returns the address for that access at once. On the next clock edge it writes the adjusted value back into the chosen pointer.

Post-increment mode accesses the current value and then moves the pointer forward by one element, which steps through an array. Pre-decrement mode first moves the pointer back by one element and accesses the moved value. A push done with pre-decrement and a pop done with post-increment on the same pointer give a last-in-first-out stack. A separate load port writes a pointer with an absolute value. The memory and the data path sit outside this block.

Top module: `ptr_autostep`

## Requirements
- R1: After a synchronous reset every pointer holds 0x0000.
- R2: Mode code 0 (plain) presents the selected pointer on `acc_addr` and leaves the pointer unchanged.
- R3: Mode code 1 (post-increment) presents the current pointer value on `acc_addr`. At the next clock edge the pointer becomes that value plus one step.
- R4: Mode code 2 (pre-decrement) presents the pointer value minus one step on `acc_addr` in the same cycle. At the next clock edge the pointer takes that value.
- R5: The step is 1 when `req_wide` is 0 (byte elements) and 2 when `req_wide` is 1 (16-bit elements).
- R6: Pointer arithmetic wraps modulo 2^16. For example, 0xFFFF post-incremented by 1 gives 0x0000, and 0x0000 pre-decremented by 2 gives 0xFFFE.
- R7: A load writes `ld_value` into pointer `ld_sel`. The new value is visible from the next cycle.
- R8: If a load and an update target the same pointer in one cycle, the load value is the one kept. If they target different pointers, both take effect.
- R9: `acc_valid` follows `req_valid`. While `req_valid` is 0, requests have no effect on any pointer.
- R10: Mode code 3 is reserved and behaves exactly like plain mode.
- R11: A series of pre-decrement pushes followed by the same number of post-increment pops on one pointer returns the pushed addresses in reverse order and restores the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_sel | input | 2 | Pointer chosen for the access |
| req_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 reserved (plain) |
| req_wide | input | 1 | Element width: 0 byte, 1 two bytes |
| ld_valid | input | 1 | Direct pointer write strobe |
| ld_sel | input | 2 | Pointer to write |
| ld_value | input | 16 | Value to write |
| acc_valid | output | 1 | Address output is valid |
| acc_addr | output | 16 | Address for the current access |

## Verification
The direct load and the automatic write-back are the two functions that can land in the same cycle. The bench drives a post-increment request on a pointer together with a load to that same pointer, and checks that the access address still comes from the old value while a later plain read returns the loaded value. It then drives a pre-decrement on one pointer together with a load on a different pointer, and checks with plain reads that both writes took effect.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN   = 2'd0,
        MODE_POSTINC = 2'd1,
        MODE_PREDEC  = 2'd2,
        MODE_RSVD    = 2'd3
    } step_mode_e;

    // Element width code to byte count
    function automatic logic [1:0] elem_bytes(input logic wide);
        return wide ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/ptr_step_calc.sv
module ptr_step_calc
    import ptr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic [PTR_W-1:0] cur,
    input  step_mode_e       mode,
    input  logic             wide,
    output logic [PTR_W-1:0] addr,
    output logic [PTR_W-1:0] next,
    output logic             writes
);
    logic [PTR_W-1:0] step;

    always_comb begin
        step   = PTR_W'(elem_bytes(wide));
        addr   = cur;
        next   = cur;
        writes = 1'b0;
        unique case (mode)
            MODE_POSTINC: begin
                next   = cur + step;
                writes = 1'b1;
            end
            MODE_PREDEC: begin
                addr   = cur - step;
                next   = cur - step;
                writes = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank #(
    parameter int NUM_PTRS = 4,
    parameter int PTR_W    = 16,
    localparam int IDX_W   = $clog2(NUM_PTRS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           upd_en,
    input  logic [IDX_W-1:0]               upd_sel,
    input  logic [PTR_W-1:0]               upd_value,
    input  logic                           ld_en,
    input  logic [IDX_W-1:0]               ld_sel,
    input  logic [PTR_W-1:0]               ld_value,
    output logic [NUM_PTRS-1:0][PTR_W-1:0] ptrs
);
    for (genvar i = 0; i < NUM_PTRS; i++) begin : g_entry
        logic hit_ld, hit_upd;
        assign hit_ld  = ld_en  && (ld_sel  == IDX_W'(i));
        assign hit_upd = upd_en && (upd_sel == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst)          ptrs[i] <= '0;
            else if (hit_ld)  ptrs[i] <= ld_value;   // load outranks update
            else if (hit_upd) ptrs[i] <= upd_value;
        end
    end

    // Load always lands, whatever update targets the same entry
    p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> ptrs[$past(ld_sel)] == $past(ld_value));

    // Idle cycle leaves every pointer untouched
    p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && !upd_en) |=> $stable(ptrs));
endmodule

// File: rtl/ptr_autostep.sv
module ptr_autostep
    import ptr_pkg::*;
#(
    parameter int NUM_PTRS = 4,
    parameter int PTR_W    = 16,
    localparam int IDX_W   = $clog2(NUM_PTRS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_sel,
    input  logic [1:0]       req_mode,
    input  logic             req_wide,
    input  logic             ld_valid,
    input  logic [IDX_W-1:0] ld_sel,
    input  logic [PTR_W-1:0] ld_value,
    output logic             acc_valid,
    output logic [PTR_W-1:0] acc_addr
);
    logic [NUM_PTRS-1:0][PTR_W-1:0] ptrs;
    logic [PTR_W-1:0]               cur, next_val;
    logic                           writes;
    step_mode_e                     mode;

    assign mode = step_mode_e'(req_mode);
    assign cur  = ptrs[req_sel];

    ptr_step_calc #(.PTR_W(PTR_W)) calc_i (
        .cur    (cur),
        .mode   (mode),
        .wide   (req_wide),
        .addr   (acc_addr),
        .next   (next_val),
        .writes (writes)
    );

    ptr_bank #(.NUM_PTRS(NUM_PTRS), .PTR_W(PTR_W)) bank_i (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (req_valid && writes),
        .upd_sel   (req_sel),
        .upd_value (next_val),
        .ld_en     (ld_valid),
        .ld_sel    (ld_sel),
        .ld_value  (ld_value),
        .ptrs      (ptrs)
    );

    assign acc_valid = req_valid;

    logic collide;
    assign collide = ld_valid && (ld_sel == req_sel);

    // Plain and reserved codes keep the pointer equal to the address used (R2, R10)
    p_plain_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !collide && (req_mode == 2'd0 || req_mode == 2'd3))
        |=> ptrs[$past(req_sel)] == $past(acc_addr));

    // Post-increment: pointer ends one element past the address used (R3, R5)
    p_postinc_adv_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !collide && req_mode == 2'd1)
        |=> ptrs[$past(req_sel)] == $past(acc_addr) + PTR_W'($past(req_wide) ? 2 : 1));

    // Pre-decrement: pointer ends equal to the address used (R4)
    p_predec_use_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !collide && req_mode == 2'd2)
        |=> ptrs[$past(req_sel)] == $past(acc_addr));

    // Pre-decrement address sits one element below the stored pointer (R4, R6)
    p_predec_addr_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 2'd2)
        |-> acc_addr == cur - PTR_W'(req_wide ? 2 : 1));
endmodule

// File: tb/ptr_autostep_tb_top.sv
module ptr_autostep_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_sel = '0;
    logic [1:0]  req_mode = '0;
    logic        req_wide = 1'b0;
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [15:0] ld_value = '0;
    logic        acc_valid;
    logic [15:0] acc_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_autostep dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
        .req_mode(req_mode), .req_wide(req_wide), .ld_valid(ld_valid),
        .ld_sel(ld_sel), .ld_value(ld_value), .acc_valid(acc_valid),
        .acc_addr(acc_addr)
    );

    typedef struct {
        logic [15:0] addr;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] model [4];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    // Monitor: pops one expected item per valid access
    always @(negedge clk) begin
        if (!rst && acc_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected access: actual addr=%h expected no access", acc_addr);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (acc_addr !== e.addr) begin
                    errors++;
                    $display("FAIL %s: actual addr=%h expected %h", e.tag, acc_addr, e.addr);
                end
            end
        end
    end

    // Driver: one request (optionally with a load) held for one clock edge
    task automatic op(input logic [1:0] sel, input logic [1:0] mode, input logic wide,
                      input logic ld, input logic [1:0] lsel, input logic [15:0] lval,
                      input string tag);
        logic [15:0] step;
        exp_t e;
        step = wide ? 16'd2 : 16'd1;
        e.tag = tag;
        case (mode)
            2'd1: begin e.addr = model[sel]; model[sel] = model[sel] + step; end
            2'd2: begin model[sel] = model[sel] - step; e.addr = model[sel]; end
            default: e.addr = model[sel];
        endcase
        if (ld) model[lsel] = lval;
        @(posedge clk); #1;
        req_valid = 1'b1; req_sel = sel; req_mode = mode; req_wide = wide;
        ld_valid = ld; ld_sel = lsel; ld_value = lval;
        exp_q.push_back(e);
    endtask

    task automatic load(input logic [1:0] lsel, input logic [15:0] lval);
        model[lsel] = lval;
        @(posedge clk); #1;
        req_valid = 1'b0; ld_valid = 1'b1; ld_sel = lsel; ld_value = lval;
    endtask

    task automatic idle_req(input logic [1:0] sel, input string tag);
        @(posedge clk); #1;
        req_valid = 1'b0; req_sel = sel; req_mode = 2'd1; req_wide = 1'b1;
        ld_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (acc_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s: actual acc_valid=%b expected 0", tag, acc_valid);
        end
    endtask

    task automatic quiet();
        @(posedge clk); #1;
        req_valid = 1'b0; ld_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) model[i] = 16'h0000;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        for (int i = 0; i < 4; i++) op(2'(i), 2'd0, 1'b0, 1'b0, 2'd0, 16'h0, "R1 reset value");
        load(2'd0, 16'h1000); load(2'd1, 16'h2000); load(2'd2, 16'hFFFF); load(2'd3, 16'h0000);
        op(2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0, "R7 load visible");
        op(2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 16'h0, "R2 plain unchanged");
        op(2'd0, 2'd1, 1'b0, 1'b0, 2'd0, 16'h0, "R3 postinc byte");
        op(2'd0, 2'd1, 1'b1, 1'b0, 2'd0, 16'h0, "R5 postinc word");
        op(2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0, "R3 after postinc");
        op(2'd1, 2'd2, 1'b1, 1'b0, 2'd0, 16'h0, "R4 predec word");
        op(2'd1, 2'd2, 1'b0, 1'b0, 2'd0, 16'h0, "R5 predec byte");
        op(2'd1, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0, "R4 after predec");
        op(2'd2, 2'd1, 1'b0, 1'b0, 2'd0, 16'h0, "R6 postinc at top");
        op(2'd2, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0, "R6 wrapped up");
        op(2'd3, 2'd2, 1'b1, 1'b0, 2'd0, 16'h0, "R6 predec at zero");
        op(2'd3, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0, "R6 wrapped down");
        op(2'd0, 2'd3, 1'b1, 1'b0, 2'd0, 16'h0, "R10 reserved code");
        op(2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0, "R10 pointer kept");
        idle_req(2'd0, "R9 acc_valid low");
        op(2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0, "R9 no update when idle");
        op(2'd1, 2'd1, 1'b0, 1'b1, 2'd1, 16'h3000, "R8 same pointer addr");
        op(2'd1, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0, "R8 load outranks update");
        op(2'd0, 2'd2, 1'b1, 1'b1, 2'd2, 16'h4444, "R8 split addr");
        op(2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0, "R8 split update kept");
        op(2'd2, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0, "R8 split load kept");
        load(2'd3, 16'h8000);
        op(2'd3, 2'd2, 1'b1, 1'b0, 2'd0, 16'h0, "R11 push one");
        op(2'd3, 2'd2, 1'b1, 1'b0, 2'd0, 16'h0, "R11 push two");
        op(2'd3, 2'd1, 1'b1, 1'b0, 2'd0, 16'h0, "R11 pop two");
        op(2'd3, 2'd1, 1'b1, 1'b0, 2'd0, 16'h0, "R11 pop one");
        op(2'd3, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0, "R11 pointer restored");
        quiet();
        repeat (2) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending items expected 0", exp_q.size());
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule